// File: doc/BRIEF.md
# Pilot Residual Phase Estimator

This block takes the four channel-corrected pilot subcarriers of one OFDM symbol. Those pilots sit at subcarrier indices -21, -7, +7 and +21, and each was sent as ±1. The block returns four parameters of a first-order phase model: a common phase term as a cosine/sine pair, and a phase-slope term as delta·sin and delta·cos. A later stage uses these parameters to de-rotate the data subcarriers. Each pilot is treated as a small linear perturbation of a unit phasor, so every parameter is a fixed weighted sum of pilot components. The weights are 1/4, and ±2/128 or ±3/128. The hardware therefore needs only adders, shifts and one rounding step per output. It uses no arctangent and no oscillator.

Values are signed fixed point W bits wide, with unity equal to 2^(W-2). Both the input and the output are valid/ready streams. A symbol moves across an interface on any rising edge where valid and ready are both high. The source must hold `in_valid` and the pilot data steady until `in_ready` accepts them. While `out_valid` is high and `out_ready` is low, the block holds its outputs. Stalls propagate backward through three register stages, so `in_ready` drops only when all three stages are occupied and the sink is stalling.

Top module: `pilot_phase_est`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `cos_o` equals the sum of the four pilot real parts divided by 4, rounded half up and saturated to W bits.
- R3: `sin_o` equals the sum of the four pilot imaginary parts divided by 4, rounded half up and saturated to W bits.
- R4: `dsin_o` equals (2·Re[lane0] + 3·Re[lane1] − 3·Re[lane2] − 2·Re[lane3]) / 128, rounded half up. Lanes 0..3 of `pil_re` and `pil_im` occupy bits [i·W +: W] and carry subcarriers -21, -7, +7 and +21 in that order.
- R5: `dcos_o` equals (2·Im[lane3] + 3·Im[lane2] − 3·Im[lane1] − 2·Im[lane0]) / 128, rounded half up.
- R6: Rounding adds half an LSB of the result and then floors, so an exact half rounds toward plus infinity (sum −2 gives 0, sum −6 gives −1, sum 2 gives 1).
- R7: If the pipeline is empty and `out_ready` is high, a symbol accepted on edge k appears with `out_valid` high after edge k+2 and not before.
- R8: While `out_ready` stays high, `in_ready` stays high and one symbol is accepted every cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and all four outputs hold unchanged.
- R10: With three symbols held in the block and `out_ready` low, `in_ready` is 0. No symbol is lost, duplicated or reordered under any pattern of stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pilot set is valid |
| in_ready | output | 1 | Block can take a pilot set |
| pil_re | input | 4·W | Real parts of the four pilots, lane i at [i·W +: W] |
| pil_im | input | 4·W | Imaginary parts of the four pilots, same lanes |
| out_valid | output | 1 | Parameters are valid |
| out_ready | input | 1 | Sink takes the parameters |
| cos_o | output | W | Common phase cosine term |
| sin_o | output | W | Common phase sine term |
| dsin_o | output | W | Slope times sine term |
| dcos_o | output | W | Slope times cosine term |

## Verification
The delicate case is a cycle where the block hands a result to the sink and also takes a new pilot set, while every stage is full. The release of the output stage must ripple back to `in_ready` combinationally within that same cycle. The bench provokes this by keeping `in_valid` high while it toggles `out_ready` at random, including stretches long enough to fill all three stages. A scoreboard queue then judges the result: every handshake on the input pushes a model result and every handshake on the output pops one, so any dropped, repeated or stale item shows up as a mismatch. Outputs are also compared cycle to cycle for stability during stalls.

// File: rtl/pilot_phase_pkg.sv
package pilot_phase_pkg;
  localparam int NUM_PILOTS  = 4;
  localparam int AVG_SHIFT   = 2;
  localparam int SLOPE_SHIFT = 7;
  localparam int AVG_GROW    = 2;
  localparam int SLOPE_GROW  = 5;

  typedef enum logic [1:0] {
    LANE_NEG21 = 2'd0,
    LANE_NEG7  = 2'd1,
    LANE_POS7  = 2'd2,
    LANE_POS21 = 2'd3
  } lane_e;

  typedef enum logic {
    COMP_RE = 1'b0,
    COMP_IM = 1'b1
  } comp_e;
endpackage

// File: rtl/pe_quad_sum.sv
module pe_quad_sum #(
  parameter int W    = 16,
  parameter int SW   = W + 2
) (
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  input  logic signed [W-1:0]  c,
  input  logic signed [W-1:0]  d,
  output logic signed [SW-1:0] y
);
  logic signed [SW-1:0] pair_lo, pair_hi;
  always_comb begin
    pair_lo = SW'(a) + SW'(b);
    pair_hi = SW'(c) + SW'(d);
    y       = pair_lo + pair_hi;
  end
endmodule

// File: rtl/pe_slope_comb.sv
// Weighted difference 2*p0 + 3*p1 - 3*p2 - 2*p3 built from shifts and adds.
module pe_slope_comb #(
  parameter int W  = 16,
  parameter int SW = W + 5
) (
  input  logic signed [W-1:0]  p0,
  input  logic signed [W-1:0]  p1,
  input  logic signed [W-1:0]  p2,
  input  logic signed [W-1:0]  p3,
  output logic signed [SW-1:0] y
);
  logic signed [SW-1:0] x0, x1, x2, x3;
  logic signed [SW-1:0] twice0, triple1, triple2, twice3;
  logic signed [SW-1:0] pos_part, neg_part;
  always_comb begin
    x0 = SW'(p0);
    x1 = SW'(p1);
    x2 = SW'(p2);
    x3 = SW'(p3);
    twice0  = x0 <<< 1;
    triple1 = (x1 <<< 1) + x1;
    triple2 = (x2 <<< 1) + x2;
    twice3  = x3 <<< 1;
    pos_part = twice0 + triple1;
    neg_part = triple2 + twice3;
    y = pos_part - neg_part;
  end
endmodule

// File: rtl/pe_round_shift.sv
// Arithmetic right shift with round-half-up, then fit to OUT_W bits.
module pe_round_shift #(
  parameter int IN_W  = 18,
  parameter int SHIFT = 2,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);
  localparam int BW = IN_W + 1;
  localparam int KEPT = BW - SHIFT;
  localparam logic signed [BW-1:0] HALF = BW'(1) <<< (SHIFT - 1);

  logic signed [BW-1:0] biased, shifted;
  logic                 sat_hit;

  always_comb begin
    biased  = BW'(x) + HALF;
    shifted = biased >>> SHIFT;
  end

  generate
    if (KEPT <= OUT_W) begin : g_fits
      assign y       = OUT_W'(shifted);
      assign sat_hit = 1'b0;
    end else begin : g_sat
      localparam logic signed [BW-1:0] MAXV = {{(BW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
      localparam logic signed [BW-1:0] MINV = {{(BW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
      always_comb begin
        sat_hit = 1'b0;
        y = OUT_W'(shifted);
        if (shifted > MAXV) begin
          y = {1'b0, {(OUT_W-1){1'b1}}};
          sat_hit = 1'b1;
        end else if (shifted < MINV) begin
          y = {1'b1, {(OUT_W-1){1'b0}}};
          sat_hit = 1'b1;
        end
      end
    end
  endgenerate

  // R6: unsaturated result r obeys r*2^S <= x + half < (r+1)*2^S
  always_comb begin
    if (!sat_hit) begin
      p_round_half_up_r6: assert ((longint'(y) <<< SHIFT) <= longint'(x) + (longint'(1) <<< (SHIFT-1))
                               && ((longint'(y) + 1) <<< SHIFT) > longint'(x) + (longint'(1) <<< (SHIFT-1)));
    end
  end
endmodule

// File: rtl/pilot_phase_est.sv
module pilot_phase_est
  import pilot_phase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NUM_PILOTS*W-1:0]     pil_re,
  input  logic [NUM_PILOTS*W-1:0]     pil_im,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic signed [W-1:0]         cos_o,
  output logic signed [W-1:0]         sin_o,
  output logic signed [W-1:0]         dsin_o,
  output logic signed [W-1:0]         dcos_o
);
  localparam int AW = W + AVG_GROW;
  localparam int LW = W + SLOPE_GROW;

  // stage valids and ready chain
  logic v1, v2, v3;
  logic rdy1, rdy2, rdy3;
  assign rdy3 = !v3 || out_ready;
  assign rdy2 = !v2 || rdy3;
  assign rdy1 = !v1 || rdy2;
  assign in_ready  = rdy1;
  assign out_valid = v3;

  // stage 1: captured pilots, [component][lane]
  logic signed [W-1:0] s1_p [2][NUM_PILOTS];
  // stage 2: full-precision sums
  logic signed [AW-1:0] s2_avg   [2];
  logic signed [LW-1:0] s2_slope [2];
  // combinational results
  logic signed [AW-1:0] avg_c    [2];
  logic signed [LW-1:0] slope_c  [2];
  logic signed [W-1:0]  avg_r    [2];
  logic signed [W-1:0]  slope_r  [2];
  // stage 3: output registers
  logic signed [W-1:0]  s3_avg   [2];
  logic signed [W-1:0]  s3_slope [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < NUM_PILOTS; l++)
          s1_p[c][l] <= '0;
    end else if (rdy1) begin
      v1 <= in_valid;
      if (in_valid) begin
        for (int l = 0; l < NUM_PILOTS; l++) begin
          s1_p[COMP_RE][l] <= pil_re[l*W +: W];
          s1_p[COMP_IM][l] <= pil_im[l*W +: W];
        end
      end
    end
  end

  generate
    for (genvar c = 0; c < 2; c++) begin : g_comp
      pe_quad_sum #(.W(W), .SW(AW)) u_avg (
        .a(s1_p[c][LANE_NEG21]), .b(s1_p[c][LANE_NEG7]),
        .c(s1_p[c][LANE_POS7]),  .d(s1_p[c][LANE_POS21]),
        .y(avg_c[c])
      );
      if (c == COMP_RE) begin : g_re
        // slope*sin: outer-negative lane weighted +2, inner-negative +3
        pe_slope_comb #(.W(W), .SW(LW)) u_slope (
          .p0(s1_p[c][LANE_NEG21]), .p1(s1_p[c][LANE_NEG7]),
          .p2(s1_p[c][LANE_POS7]),  .p3(s1_p[c][LANE_POS21]),
          .y(slope_c[c])
        );
      end else begin : g_im
        // slope*cos: lane order mirrored, positive subcarriers weighted up
        pe_slope_comb #(.W(W), .SW(LW)) u_slope (
          .p0(s1_p[c][LANE_POS21]), .p1(s1_p[c][LANE_POS7]),
          .p2(s1_p[c][LANE_NEG7]),  .p3(s1_p[c][LANE_NEG21]),
          .y(slope_c[c])
        );
      end
      pe_round_shift #(.IN_W(AW), .SHIFT(AVG_SHIFT), .OUT_W(W)) u_avg_rnd (
        .x(s2_avg[c]), .y(avg_r[c])
      );
      pe_round_shift #(.IN_W(LW), .SHIFT(SLOPE_SHIFT), .OUT_W(W)) u_slope_rnd (
        .x(s2_slope[c]), .y(slope_r[c])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        s2_avg[c]   <= '0;
        s2_slope[c] <= '0;
      end
    end else if (rdy2) begin
      v2 <= v1;
      if (v1) begin
        for (int c = 0; c < 2; c++) begin
          s2_avg[c]   <= avg_c[c];
          s2_slope[c] <= slope_c[c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v3 <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        s3_avg[c]   <= '0;
        s3_slope[c] <= '0;
      end
    end else if (rdy3) begin
      v3 <= v2;
      if (v2) begin
        for (int c = 0; c < 2; c++) begin
          s3_avg[c]   <= avg_r[c];
          s3_slope[c] <= slope_r[c];
        end
      end
    end
  end

  assign cos_o  = s3_avg[COMP_RE];
  assign sin_o  = s3_avg[COMP_IM];
  assign dsin_o = s3_slope[COMP_RE];
  assign dcos_o = s3_slope[COMP_IM];

  // R9: a stalled result holds
  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cos_o) && $stable(sin_o)
                                 && $stable(dsin_o) && $stable(dcos_o));

  // R10: a full, stalled pipeline refuses input
  p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    v1 && v2 && v3 && !out_ready |-> !in_ready);

  // R7: a result only appears from the sum stage
  p_result_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(v2));

  // R8: with the sink ready, a summed item reaches the output next cycle
  p_stream_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    v2 && out_ready |=> out_valid);
endmodule

// File: tb/sim_pilot_phase_est.sv
module sim_pilot_phase_est;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4*W-1:0] pil_re = '0;
  logic [4*W-1:0] pil_im = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [W-1:0] cos_o, sin_o, dsin_o, dcos_o;

  always #4 clk = ~clk;

  pilot_phase_est #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pil_re(pil_re), .pil_im(pil_im), .out_valid(out_valid), .out_ready(out_ready),
    .cos_o(cos_o), .sin_o(sin_o), .dsin_o(dsin_o), .dcos_o(dcos_o)
  );

  typedef struct { int c; int s; int ds; int dc; } exp_t;
  exp_t sb_q[$];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int bp_mode = 0;   // 0: out_ready high, 1: random, 2: held low

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int rnd_sh(input int v, input int sh);
    int r;
    r = (v + (1 <<< (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic exp_t model(input int re[4], input int im[4]);
    exp_t e;
    e.c  = rnd_sh(re[0] + re[1] + re[2] + re[3], 2);
    e.s  = rnd_sh(im[0] + im[1] + im[2] + im[3], 2);
    e.ds = rnd_sh(2*re[0] + 3*re[1] - 3*re[2] - 2*re[3], 7);
    e.dc = rnd_sh(2*im[3] + 3*im[2] - 3*im[1] - 2*im[0], 7);
    return e;
  endfunction

  task automatic drive_ready();
    if (bp_mode == 0) out_ready = 1'b1;
    else if (bp_mode == 1) out_ready = $urandom_range(0, 1) == 1;
    else out_ready = 1'b0;
  endtask

  // driver: drives at negedge, pushes the expected item when the handshake will occur
  task automatic send(input int re[4], input int im[4], input bit expect_first);
    bit first = 1;
    forever begin
      @(negedge clk);
      drive_ready();
      in_valid = 1'b1;
      for (int l = 0; l < 4; l++) begin
        pil_re[l*W +: W] = W'(re[l]);
        pil_im[l*W +: W] = W'(im[l]);
      end
      #1;
      if (expect_first && first) chk(in_ready, "R8 in_ready", int'(in_ready), 1);
      first = 0;
      if (in_ready) begin
        sb_q.push_back(model(re, im));
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive_ready();
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops and compares on output handshakes, checks stall hold
  bit prev_stall = 0;
  logic signed [W-1:0] pc, ps, pds, pdc;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid && cos_o == pc && sin_o == ps && dsin_o == pds && dcos_o == pdc,
            "R9 hold", int'(cos_o), int'(pc));
      end
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          chk(0, "R10 unexpected output", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(cos_o == e.c,   "R2/R6 cos",  int'(cos_o),  e.c);
          chk(sin_o == e.s,   "R3 sin",     int'(sin_o),  e.s);
          chk(dsin_o == e.ds, "R4 dsin",    int'(dsin_o), e.ds);
          chk(dcos_o == e.dc, "R5 dcos",    int'(dcos_o), e.dc);
        end
      end
      prev_stall = out_valid && !out_ready;
      pc = cos_o; ps = sin_o; pds = dsin_o; pdc = dcos_o;
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int re[4];
    int im[4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1,  "R1 in_ready",  int'(in_ready), 1);

    // R7 latency with an empty pipeline
    bp_mode = 0;
    re = '{16384, 16384, 16384, 16384}; im = '{0, 0, 0, 0};
    send(re, im, 0);
    @(negedge clk); in_valid = 1'b0; #1;
    chk(out_valid == 0, "R7 after k", int'(out_valid), 0);
    @(negedge clk); #1;
    chk(out_valid == 0, "R7 after k+1", int'(out_valid), 0);
    @(negedge clk); #1;
    chk(out_valid == 1, "R7 after k+2", int'(out_valid), 1);
    idle(3);

    // R6 rounding corners and R2..R5 directed patterns
    re = '{-2, 0, 0, 0};    im = '{2, 0, 0, 0};   send(re, im, 0);   // cos 0, sin 1
    re = '{-6, 0, 0, 0};    im = '{-5, 0, 0, 0};  send(re, im, 0);   // cos -1, sin -1
    re = '{0, 64, 0, 0};    im = '{0, 0, 0, -64}; send(re, im, 0);   // slope halves
    re = '{32767, 32767, -32768, -32768}; im = '{-32768, -32768, 32767, 32767}; send(re, im, 0);
    re = '{-32768, -32768, -32768, -32768}; im = '{32767, 32767, 32767, 32767}; send(re, im, 0);
    re = '{16000, 16200, 16500, 16700}; im = '{-900, -300, 300, 900}; send(re, im, 0);
    idle(5);

    // R8 back-to-back throughput
    bp_mode = 0;
    for (int n = 0; n < 20; n++) begin
      for (int l = 0; l < 4; l++) begin
        re[l] = $urandom_range(0, 65535) - 32768;
        im[l] = $urandom_range(0, 65535) - 32768;
      end
      send(re, im, 1);
    end
    idle(5);

    // R10 fill three stages under stall, fourth must be refused
    bp_mode = 2;
    for (int n = 0; n < 3; n++) begin
      re = '{n*100, 1, 2, 3}; im = '{3, 2, 1, n*50};
      send(re, im, 0);
    end
    @(negedge clk);
    drive_ready();
    in_valid = 1'b1;
    #1;
    chk(in_ready == 0, "R10 full stall", int'(in_ready), 0);
    in_valid = 1'b0;
    idle(3);
    bp_mode = 0;
    idle(6);

    // random back-pressure with continuous input
    bp_mode = 1;
    for (int n = 0; n < 300; n++) begin
      for (int l = 0; l < 4; l++) begin
        re[l] = $urandom_range(0, 65535) - 32768;
        im[l] = $urandom_range(0, 65535) - 32768;
      end
      send(re, im, 0);
    end
    bp_mode = 0;
    idle(8);
    chk(sb_q.size() == 0, "R10 drained", sb_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule